// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block sits between a processor's memory port and the memory system. Stores from the processor are parked in a small in-order queue and leave for memory one at a time, oldest first, whenever the memory port is free and ready. Loads do not wait behind them. Every incoming load address is compared with all occupied queue slots. When a slot matches, the load is answered from the queue, using the most recently written matching slot, and memory never sees that load. When no slot matches, the load is sent to memory ahead of the parked stores. This is safe because none of those stores touch its address.

A load and a store that share an address therefore keep program order, while accesses to different addresses may be reordered. Ordering logic outside the block, such as a fence, can wait on the empty flag. At that point every earlier store has reached memory.

Top module: `store_buffer`

## Requirements
- R1: After reset the queue is empty: `sb_empty` is 1, `mem_req_valid` is 0, `ld_rsp_valid` is 0, and `cpu_req_ready` is 1 for a store request.
- R2: Buffered stores are presented on the memory port (`mem_req_is_store`=1) in the order they were accepted. Each one is removed on the cycle that `mem_req_valid` and `mem_req_ready` are both 1.
- R3: In a cycle where a load that matched no slot and at least one buffered store both need the memory port, the port carries the load (`mem_req_is_store`=0).
- R4: A load whose address equals the address of an occupied slot is not sent to memory. Its data appears on `ld_rsp_data` with `ld_rsp_valid`=1 in the cycle after the load is accepted.
- R5: When several occupied slots match a load, the returned data is that of the most recently accepted matching store.
- R6: A load that matches no slot is accepted only together with `mem_req_ready`. The memory response (`mem_rsp_valid`, `mem_rsp_data`) is passed to `ld_rsp_valid`/`ld_rsp_data` in the same cycle.
- R7: When DEPTH stores are buffered, `cpu_req_ready` is 0 for a store request, and no accepted store is lost or overwritten.
- R8: `sb_empty` is 1 exactly when no store is buffered. While it is 1, no store request is shown on the memory port.
- R9: Only one load is in flight. After a load is accepted, `cpu_req_ready` stays 0 for loads until that load's response has been returned.
- R10: Once a store has left for memory it no longer forwards. A later load to its address is sent to memory and returns the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request accepted this cycle if valid |
| cpu_req_is_store | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | AW | Request address |
| cpu_req_wdata | input | DW | Store data |
| ld_rsp_valid | output | 1 | Load data returned |
| ld_rsp_data | output | DW | Returned load data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_is_store | output | 1 | 1 = store drain, 0 = load |
| mem_req_addr | output | AW | Memory request address |
| mem_req_wdata | output | DW | Memory store data |
| mem_rsp_valid | input | 1 | Memory load data valid |
| mem_rsp_data | input | DW | Memory load data |
| sb_empty | output | 1 | No stores pending |

## Verification
The bench uses the default build of 8 slots and 32-bit address and data. With this depth the queue can be filled completely while memory is held not-ready, which exposes the full-stall boundary. It also allows several same-address stores to sit in the queue at once, so the youngest-match choice is exercised across the pointer wrap. Addresses are restricted to a few words, so a random mix of loads, stores and memory back-pressure produces frequent hits, multiple matches and loads that overtake older stores.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic {
    MEM_OP_LOAD  = 1'b0,
    MEM_OP_STORE = 1'b1
  } mem_op_e;

  // Advance a circular pointer by one slot.
  function automatic int next_slot(input int ptr, input int depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

  // Distance of a slot from the oldest one; larger means younger.
  function automatic int slot_age(input int idx, input int head, input int depth);
    return (idx - head + depth) % depth;
  endfunction

endpackage

// File: rtl/sb_ctrl.sv
module sb_ctrl #(
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [PW-1:0] head,
  output logic [PW-1:0] tail,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  import sb_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) tail <= PW'(next_slot(int'(tail), DEPTH));
      if (pop)  head <= PW'(next_slot(int'(head), DEPTH));
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

endmodule

// File: rtl/sb_storage.sv
module sb_storage #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PW-1:0]    wr_idx,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  input  logic [PW-1:0]    head_idx,
  output logic [AW-1:0]    head_addr,
  output logic [DW-1:0]    head_data,
  input  logic [AW-1:0]    lk_addr,
  output logic             lk_hit,
  output logic [DW-1:0]    lk_data,
  output logic [DEPTH-1:0] valid_vec
);
  import sb_pkg::*;

  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [DEPTH-1:0] valid_q;
  logic [DEPTH-1:0] match;
  logic [PW-1:0]    sel;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) valid_q[i] <= 1'b0;
      else if (wr_en && wr_idx == PW'(i)) valid_q[i] <= 1'b1;
      else if (rd_en && head_idx == PW'(i)) valid_q[i] <= 1'b0;
    end
    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == PW'(i)) begin
        addr_q[i] <= wr_addr;
        data_q[i] <= wr_data;
      end
    end
    assign match[i] = valid_q[i] && (addr_q[i] == lk_addr);
  end

  // Pick the matching slot with the greatest age from the head (youngest).
  always_comb begin
    int best;
    best = -1;
    sel  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i] && slot_age(i, int'(head_idx), DEPTH) > best) begin
        best = slot_age(i, int'(head_idx), DEPTH);
        sel  = PW'(i);
      end
    end
  end

  assign lk_hit    = |match;
  assign lk_data   = data_q[sel];
  assign head_addr = addr_q[head_idx];
  assign head_data = data_q[head_idx];
  assign valid_vec = valid_q;

  p_write_free_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !valid_q[wr_idx]);
  p_drain_live_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> valid_q[head_idx]);

endmodule

// File: rtl/sb_port_arb.sv
module sb_port_arb #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  input  logic          ld_hit,
  input  logic [DW-1:0] ld_hit_data,
  output logic          ld_ready,
  input  logic          st_pending,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  output logic          st_pop,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_is_store,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          ld_rsp_valid,
  output logic [DW-1:0] ld_rsp_data
);
  import sb_pkg::*;

  logic          fwd_q, miss_q;
  logic [DW-1:0] fwd_data_q;
  logic          busy, ld_go_mem, ld_take_hit;
  mem_op_e       port_op;

  assign busy        = fwd_q || miss_q;
  assign ld_go_mem   = ld_valid && !busy && !ld_hit;
  assign ld_take_hit = ld_valid && !busy && ld_hit;
  assign ld_ready    = !busy && (ld_hit || mem_req_ready);

  // The load owns the port whenever it needs it.
  assign port_op          = ld_go_mem ? MEM_OP_LOAD : MEM_OP_STORE;
  assign mem_req_valid    = ld_go_mem || st_pending;
  assign mem_req_is_store = (port_op == MEM_OP_STORE);
  assign mem_req_addr     = ld_go_mem ? ld_addr : head_addr;
  assign mem_req_wdata    = ld_go_mem ? '0 : head_data;
  assign st_pop           = st_pending && !ld_go_mem && mem_req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_q  <= 1'b0;
      miss_q <= 1'b0;
    end else begin
      fwd_q <= ld_take_hit;
      if (ld_go_mem && mem_req_ready) miss_q <= 1'b1;
      else if (mem_rsp_valid)         miss_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_take_hit) fwd_data_q <= ld_hit_data;
  end

  assign ld_rsp_valid = fwd_q || (miss_q && mem_rsp_valid);
  assign ld_rsp_data  = fwd_q ? fwd_data_q : mem_rsp_data;

  p_load_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !ld_hit && !busy && st_pending) |-> (mem_req_valid && !mem_req_is_store));
  p_hit_not_to_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_hit) |-> !(mem_req_valid && !mem_req_is_store));
  p_hit_answer_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_hit && ld_ready) |=> ld_rsp_valid);
  p_single_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready) |=> !ld_ready);

endmodule

// File: rtl/store_buffer.sv
module store_buffer #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req_valid,
  output logic          cpu_req_ready,
  input  logic          cpu_req_is_store,
  input  logic [AW-1:0] cpu_req_addr,
  input  logic [DW-1:0] cpu_req_wdata,
  output logic          ld_rsp_valid,
  output logic [DW-1:0] ld_rsp_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_is_store,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          sb_empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic             st_push, st_pop, q_full, q_empty, ld_valid, ld_ready;
  logic             lk_hit;
  logic [DW-1:0]    lk_data, head_data;
  logic [AW-1:0]    head_addr;
  logic [PW-1:0]    head, tail;
  logic [CW-1:0]    count;
  logic [DEPTH-1:0] valid_vec;

  assign st_push       = cpu_req_valid && cpu_req_is_store && !q_full;
  assign ld_valid      = cpu_req_valid && !cpu_req_is_store;
  assign cpu_req_ready = cpu_req_is_store ? !q_full : ld_ready;
  assign sb_empty      = q_empty;

  sb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .push(st_push), .pop(st_pop),
    .head(head), .tail(tail), .count(count), .full(q_full), .empty(q_empty)
  );

  sb_storage #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(st_push), .wr_idx(tail), .wr_addr(cpu_req_addr), .wr_data(cpu_req_wdata),
    .rd_en(st_pop), .head_idx(head), .head_addr(head_addr), .head_data(head_data),
    .lk_addr(cpu_req_addr), .lk_hit(lk_hit), .lk_data(lk_data), .valid_vec(valid_vec)
  );

  sb_port_arb #(.AW(AW), .DW(DW)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_addr(cpu_req_addr), .ld_hit(lk_hit), .ld_hit_data(lk_data),
    .ld_ready(ld_ready),
    .st_pending(!q_empty), .head_addr(head_addr), .head_data(head_data), .st_pop(st_pop),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_is_store(mem_req_is_store), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .ld_rsp_valid(ld_rsp_valid), .ld_rsp_data(ld_rsp_data)
  );

  p_slots_match_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(valid_vec) == int'(count));
  p_empty_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sb_empty |-> !(mem_req_valid && mem_req_is_store));
  p_full_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sb_empty && $countones(valid_vec) == DEPTH && cpu_req_is_store) |-> !cpu_req_ready);

endmodule

// File: tb/tb_store_buffer.sv
module tb_store_buffer;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0, cpu_req_is_store = 1'b0;
  logic [31:0] cpu_req_addr = '0, cpu_req_wdata = '0;
  logic        cpu_req_ready, ld_rsp_valid, mem_req_valid, mem_req_is_store, sb_empty;
  logic [31:0] ld_rsp_data, mem_req_addr, mem_req_wdata;
  logic        mem_rdy = 1'b0;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int n_checks = 0, n_fail = 0, mem_loads = 0;
  logic        rnd_mem = 1'b0;
  logic [31:0] ref_mem [16];
  logic [31:0] mem_arr [16];
  logic [31:0] ld_q [$];
  string       ld_tag [$];
  logic [63:0] st_q [$];

  always #10 clk = ~clk;

  store_buffer #(.DEPTH(DEPTH), .AW(32), .DW(32)) dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_is_store(cpu_req_is_store), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata),
    .ld_rsp_valid(ld_rsp_valid), .ld_rsp_data(ld_rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_rdy),
    .mem_req_is_store(mem_req_is_store), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .sb_empty(sb_empty)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory model: stores checked against program order, loads answered next cycle.
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (rst_n && mem_req_valid && mem_rdy) begin
      if (mem_req_is_store) begin
        logic [63:0] e;
        e = (st_q.size() > 0) ? st_q.pop_front() : 64'hDEAD;
        check({mem_req_addr, mem_req_wdata} == e, "R2 drain order",
              {mem_req_addr, mem_req_wdata}, e);
        mem_arr[mem_req_addr[5:2]] = mem_req_wdata;
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem_arr[mem_req_addr[5:2]];
        mem_loads++;
      end
    end
  end

  // Load-result monitor.
  always @(negedge clk) begin
    if (rst_n && ld_rsp_valid) begin
      logic [31:0] e;
      string t;
      e = (ld_q.size() > 0) ? ld_q.pop_front() : 32'hBAD0BAD0;
      t = (ld_tag.size() > 0) ? ld_tag.pop_front() : "R4 unexpected";
      check(ld_rsp_data == e, t, ld_rsp_data, e);
    end
  end

  // Random memory back-pressure for the mixed phase.
  logic [15:0] bp_lfsr = 16'hACE1;
  always @(negedge clk) begin
    if (rnd_mem) begin
      bp_lfsr = {bp_lfsr[14:0], bp_lfsr[15] ^ bp_lfsr[13] ^ bp_lfsr[12] ^ bp_lfsr[10]};
      mem_rdy = bp_lfsr[0] | bp_lfsr[1];
    end
  end

  task automatic issue(input logic st, input logic [31:0] a, input logic [31:0] d,
                       input string tag, output int waits);
    waits = 0;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_is_store = st; cpu_req_addr = a; cpu_req_wdata = d;
    #1;
    while (!cpu_req_ready) begin
      waits++;
      @(negedge clk); #1;
    end
    if (st) begin
      ref_mem[a[5:2]] = d;
      st_q.push_back({a, d});
    end else begin
      ld_q.push_back(ref_mem[a[5:2]]);
      ld_tag.push_back(tag);
    end
    @(posedge clk); #1;
    cpu_req_valid = 1'b0;
  endtask

  function automatic logic [31:0] wa(input int w);
    return 32'(w) << 2;
  endfunction

  task automatic drain_all();
    mem_rdy = 1'b1;
    for (int i = 0; i < 100 && !sb_empty; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int w, ml;
    for (int i = 0; i < 16; i++) begin
      ref_mem[i] = 32'hA000_0000 + 32'(i);
      mem_arr[i] = 32'hA000_0000 + 32'(i);
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cpu_req_is_store = 1'b1; #1;
    check(sb_empty == 1'b1, "R1 empty after reset", sb_empty, 1);
    check(mem_req_valid == 1'b0, "R1 mem idle after reset", mem_req_valid, 0);
    check(ld_rsp_valid == 1'b0, "R1 no load data after reset", ld_rsp_valid, 0);
    check(cpu_req_ready == 1'b1, "R1 store ready after reset", cpu_req_ready, 1);

    // Forwarding with memory stalled.
    mem_rdy = 1'b0;
    issue(1, wa(1), 32'h11, "", w);
    issue(1, wa(2), 32'h22, "", w);
    issue(1, wa(1), 32'h33, "", w);
    @(negedge clk);
    check(sb_empty == 1'b0, "R8 not empty with stores", sb_empty, 0);
    ml = mem_loads;
    issue(0, wa(1), 0, "R5 youngest match", w);
    issue(0, wa(2), 0, "R4 forward", w);
    repeat (2) @(negedge clk);
    check(mem_loads == ml, "R4 hit kept off memory", mem_loads, ml);

    // Load miss overtakes pending stores.
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_is_store = 1'b0; cpu_req_addr = wa(5); #1;
    check(mem_req_valid && !mem_req_is_store, "R3 load owns port",
          {mem_req_valid, mem_req_is_store}, 2'b10);
    check(mem_req_addr == wa(5), "R3 load address on port", mem_req_addr, wa(5));
    check(cpu_req_ready == 1'b0, "R6 miss waits for memory ready", cpu_req_ready, 0);
    cpu_req_valid = 1'b0;
    mem_rdy = 1'b1;
    issue(0, wa(5), 0, "R6 miss from memory", w);
    issue(0, wa(6), 0, "R6 second miss", w);
    check(w == 1, "R9 second load held one cycle", w, 1);
    drain_all();
    check(sb_empty == 1'b1, "R8 empty after drain", sb_empty, 1);

    // Fill to capacity.
    mem_rdy = 1'b0;
    for (int i = 0; i < DEPTH; i++) issue(1, wa(8 + (i % 4)), 32'h100 + 32'(i), "", w);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_is_store = 1'b1; cpu_req_addr = wa(3);
    cpu_req_wdata = 32'h999; #1;
    check(cpu_req_ready == 1'b0, "R7 full stalls store", cpu_req_ready, 0);
    cpu_req_valid = 1'b0;
    issue(0, wa(9), 0, "R5 youngest across full queue", w);
    mem_rdy = 1'b1;
    issue(1, wa(3), 32'h999, "", w);
    drain_all();
    check(sb_empty == 1'b1, "R8 empty after full drain", sb_empty, 1);

    // Drained stores no longer forward.
    ml = mem_loads;
    issue(0, wa(9), 0, "R10 load after drain", w);
    repeat (2) @(negedge clk);
    check(mem_loads == ml + 1, "R10 load reached memory", mem_loads, ml + 1);

    // Mixed traffic under random back-pressure.
    rnd_mem = 1'b1;
    begin
      logic [31:0] lf;
      lf = 32'h1234_5679;
      for (int i = 0; i < 400; i++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        issue(lf[2], wa(int'(lf[6:4])), lf ^ 32'hC0DE_0000, "R5 mixed load", w);
      end
    end
    rnd_mem = 1'b0;
    drain_all();
    check(st_q.size() == 0, "R2 all stores drained", st_q.size(), 0);
    check(ld_q.size() == 0, "R4 all loads answered", ld_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule